// File: doc/BRIEF.md
# Dual Redundant Reference Selector with Prescaler

This block prepares the reference for a digital PLL from two redundant paths, called A (primary) and B (secondary). Each path has its own source selector. The selector can pick any one of up to 32 per-stream TDM input clocks, or an external reference pin that belongs to that path alone.

The chosen clock is brought into the system clock domain through a two-flop synchronizer, and its rising edges are detected there. An integer prescaler then counts those edges. Every N edges it emits a one-cycle enable pulse, where N comes from that path's divider input. A divider value of zero is not a ratio: it turns the path's reference off.

Each path also drives a health flag. The flag is high while the divider is nonzero and edges keep arriving within a programmable timeout. A select input chooses which path feeds the PLL. The hand-over between paths is delayed until the newly chosen path produces a pulse, so the PLL never sees a shortened or extra reference period.

Top module: `dual_ref_prescaler`

## Requirements
- R1: Source select codes are the same for both paths. Codes 0..N_STREAMS-1 pick `stream_clk[code]`. Code N_STREAMS (32 by default) picks the path's own external pin (`ext_ref_a` for path A, `ext_ref_b` for path B). Any higher code picks no source, so the path produces no pulses.
- R2: With a nonzero divider N, a path emits exactly one pulse per N rising edges of its selected source. The first pulse comes on the N-th edge after the edge counter was last cleared.
- R3: A divider value of 1 passes every detected rising edge through as one pulse.
- R4: A divider value of 0 suppresses all pulses of that path and holds its health flag low.
- R5: Divider values up to 2^DIV_W-1 are supported; a ratio of 2796 yields one pulse per 2796 edges.
- R6: A new divider value takes effect only at the path's next output pulse. It takes effect at once only when the source select changes or when the active divider is zero.
- R7: A path's health flag rises on a detected edge while its active divider is nonzero. It falls once `tmo_limit` system cycles pass with no further edge.
- R8: Any change of a path's source select clears that path's edge counter and its health flag. The flag stays low until a fresh edge arrives.
- R9: A change of `use_b` moves `pll_ref` to the other path only on that path's next pulse, and that pulse itself is passed on. `pll_ref` is the active path's pulse delayed by one cycle. `pll_ref_ok` follows the active path's health flag. `pll_src_b` is 1 when path B is active.
- R10: Every output pulse lasts one system cycle. After reset all outputs are 0 and path A is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stream_clk | input | N_STREAMS | Per-stream TDM input clocks, shared by both paths |
| ext_ref_a | input | 1 | External reference pin of path A |
| ext_ref_b | input | 1 | External reference pin of path B |
| src_sel_a | input | SEL_W | Source select code of path A |
| src_sel_b | input | SEL_W | Source select code of path B |
| div_a | input | DIV_W | Divider ratio of path A, 0 = off |
| div_b | input | DIV_W | Divider ratio of path B, 0 = off |
| tmo_limit | input | TMO_W | Edge-absence timeout in system cycles |
| use_b | input | 1 | Requested PLL path: 0 = A, 1 = B |
| ref_pulse_a | output | 1 | Divided reference pulse of path A |
| ref_pulse_b | output | 1 | Divided reference pulse of path B |
| ref_ok_a | output | 1 | Health flag of path A |
| ref_ok_b | output | 1 | Health flag of path B |
| pll_ref | output | 1 | Reference pulse presented to the PLL |
| pll_ref_ok | output | 1 | Health flag of the active path |
| pll_src_b | output | 1 | Active path, 1 = B |

## Verification
The bench builds the block with its default parameters: 32 streams, a 6-bit select code, a 12-bit divider and a 16-bit timeout. It runs the timeout at 40 cycles, so a loss of reference is seen within a short idle gap. The 12-bit divider makes the 2796 ratio reachable. The 6-bit code reaches the external-pin code 32, the first unused code 33 and the idle code 63, so every class of select code is exercised. Both paths run in lockstep on shared stimulus, so the A/B hand-over can be checked against known pulse phases.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic {
        PATH_A = 1'b0,
        PATH_B = 1'b1
    } path_e;

    localparam int NUM_PATHS = 2;

endpackage

// File: rtl/refsel_edge_sync.sv
module refsel_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], raw_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

endmodule

// File: rtl/refsel_div_core.sv
module refsel_div_core #(
    parameter int DIV_W = 12,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_req,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             pulse,
    output logic             ok,
    output logic [DIV_W-1:0] div_act
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic [TMO_W-1:0] tmr;
        logic             ok;
        logic             pulse;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    load;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        load       = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
            st_d.act = div_req;
            st_d.tmr = '0;
            st_d.ok  = 1'b0;
        end else begin
            load = (st_q.act == '0);
            if (rise && st_q.act != '0) begin
                if ({1'b0, st_q.cnt} + CW'(1) >= {1'b0, st_q.act}) begin
                    st_d.pulse = 1'b1;
                    st_d.cnt   = '0;
                    load       = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + DIV_W'(1);
                end
            end
            if (load) st_d.act = div_req;
            if (rise) begin
                st_d.tmr = '0;
                st_d.ok  = (st_d.act != '0);
            end else if (st_q.tmr >= tmo_limit) begin
                st_d.ok = 1'b0;
            end else begin
                st_d.tmr = st_q.tmr + TMO_W'(1);
            end
            if (st_d.act == '0) st_d.ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse   = st_q.pulse;
    assign ok      = st_q.ok;
    assign div_act = st_q.act;

endmodule

// File: rtl/refsel_path.sv
module refsel_path #(
    parameter int N_STREAMS = 32,
    parameter int SEL_W     = 6,
    parameter int DIV_W     = 12,
    parameter int TMO_W     = 16,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STREAMS-1:0] streams,
    input  logic                 ext_ref,
    input  logic [SEL_W-1:0]     sel,
    input  logic [DIV_W-1:0]     div_req,
    input  logic [TMO_W-1:0]     tmo_limit,
    output logic                 pulse,
    output logic                 ok,
    output logic [DIV_W-1:0]     div_act
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } path_st_t;

    path_st_t st_d, st_q;
    logic     raw_ref;
    logic     rise;
    logic     restart;

    always_comb begin
        raw_ref = 1'b0;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (sel == SEL_W'(i)) raw_ref = streams[i];
        end
        if (sel == SEL_W'(N_STREAMS)) raw_ref = ext_ref;
    end

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel;
        restart  = (sel != st_q.sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    refsel_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_ref),
        .rise   (rise)
    );

    refsel_div_core #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .restart   (restart),
        .div_req   (div_req),
        .tmo_limit (tmo_limit),
        .pulse     (pulse),
        .ok        (ok),
        .div_act   (div_act)
    );

endmodule

// File: rtl/dual_ref_prescaler.sv
module dual_ref_prescaler
    import refsel_pkg::*;
#(
    parameter int N_STREAMS = 32,
    parameter int SEL_W     = $clog2(N_STREAMS + 2),
    parameter int DIV_W     = 12,
    parameter int TMO_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STREAMS-1:0] stream_clk,
    input  logic                 ext_ref_a,
    input  logic                 ext_ref_b,
    input  logic [SEL_W-1:0]     src_sel_a,
    input  logic [SEL_W-1:0]     src_sel_b,
    input  logic [DIV_W-1:0]     div_a,
    input  logic [DIV_W-1:0]     div_b,
    input  logic [TMO_W-1:0]     tmo_limit,
    input  logic                 use_b,
    output logic                 ref_pulse_a,
    output logic                 ref_pulse_b,
    output logic                 ref_ok_a,
    output logic                 ref_ok_b,
    output logic                 pll_ref,
    output logic                 pll_ref_ok,
    output logic                 pll_src_b
);
    logic [NUM_PATHS-1:0] ext_v;
    logic [SEL_W-1:0]     sel_v  [NUM_PATHS];
    logic [DIV_W-1:0]     div_v  [NUM_PATHS];
    logic [DIV_W-1:0]     act_v  [NUM_PATHS];
    logic [NUM_PATHS-1:0] pulse_v;
    logic [NUM_PATHS-1:0] ok_v;
    logic [DIV_W-1:0]     act_div_a;
    logic [DIV_W-1:0]     act_div_b;

    assign ext_v    = {ext_ref_b, ext_ref_a};
    assign sel_v[0] = src_sel_a;
    assign sel_v[1] = src_sel_b;
    assign div_v[0] = div_a;
    assign div_v[1] = div_b;

    for (genvar gi = 0; gi < NUM_PATHS; gi++) begin : g_path
        refsel_path #(
            .N_STREAMS (N_STREAMS),
            .SEL_W     (SEL_W),
            .DIV_W     (DIV_W),
            .TMO_W     (TMO_W)
        ) u_path (
            .clk       (clk),
            .rst_n     (rst_n),
            .streams   (stream_clk),
            .ext_ref   (ext_v[gi]),
            .sel       (sel_v[gi]),
            .div_req   (div_v[gi]),
            .tmo_limit (tmo_limit),
            .pulse     (pulse_v[gi]),
            .ok        (ok_v[gi]),
            .div_act   (act_v[gi])
        );
    end

    assign act_div_a = act_v[0];
    assign act_div_b = act_v[1];

    typedef struct packed {
        path_e cur;
        logic  ref_o;
        logic  ok_o;
    } sw_st_t;

    sw_st_t st_d, st_q;
    path_e  want;

    always_comb begin
        st_d = st_q;
        want = use_b ? PATH_B : PATH_A;
        if (want != st_q.cur && pulse_v[want]) st_d.cur = want;
        st_d.ref_o = pulse_v[st_d.cur];
        st_d.ok_o  = ok_v[st_d.cur];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cur: PATH_A, ref_o: 1'b0, ok_o: 1'b0};
        else        st_q <= st_d;
    end

    assign ref_pulse_a = pulse_v[0];
    assign ref_pulse_b = pulse_v[1];
    assign ref_ok_a    = ok_v[0];
    assign ref_ok_b    = ok_v[1];
    assign pll_ref     = st_q.ref_o;
    assign pll_ref_ok  = st_q.ok_o;
    assign pll_src_b   = (st_q.cur == PATH_B);

endmodule

// File: rtl/dual_ref_prescaler_chk.sv
module dual_ref_prescaler_chk #(
    parameter int SEL_W = 6,
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] src_sel_a,
    input logic [SEL_W-1:0] src_sel_b,
    input logic             ref_pulse_a,
    input logic             ref_pulse_b,
    input logic             ref_ok_a,
    input logic             ref_ok_b,
    input logic             pll_ref,
    input logic             pll_src_b,
    input logic [DIV_W-1:0] act_div_a,
    input logic [DIV_W-1:0] act_div_b
);
    // R10
    pulse_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_a |=> !ref_pulse_a);
    // R10
    pulse_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_b |=> !ref_pulse_b);
    // R4
    zero_div_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_a |-> $past(act_div_a) != '0);
    // R4
    zero_div_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse_b |-> $past(act_div_b) != '0);
    // R7
    ok_needs_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok_a |-> act_div_a != '0) and (ref_ok_b |-> act_div_b != '0));
    // R8
    sel_clear_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_a != $past(src_sel_a)) |=> !ref_ok_a);
    // R8
    sel_clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_b != $past(src_sel_b)) |=> !ref_ok_b);
    // R9
    switch_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_src_b) |-> $past(ref_pulse_b));
    // R9
    switch_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_src_b) |-> $past(ref_pulse_a));
    // R9
    pll_from_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ref |-> $past(ref_pulse_a || ref_pulse_b));
endmodule

bind dual_ref_prescaler dual_ref_prescaler_chk #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel_a   (src_sel_a),
    .src_sel_b   (src_sel_b),
    .ref_pulse_a (ref_pulse_a),
    .ref_pulse_b (ref_pulse_b),
    .ref_ok_a    (ref_ok_a),
    .ref_ok_b    (ref_ok_b),
    .pll_ref     (pll_ref),
    .pll_src_b   (pll_src_b),
    .act_div_a   (act_div_a),
    .act_div_b   (act_div_b)
);

// File: tb/dual_ref_prescaler_bench.sv
module dual_ref_prescaler_bench;
    localparam int NS = 32;
    localparam int SW = 6;
    localparam int DW = 12;
    localparam int TW = 16;
    localparam int NV = 9;

    // vector table: select code, divider, edges driven, pulses expected
    localparam int V_SEL [NV] = '{0, 31, 32, 7, 32, 15, 1, 33, 3};
    localparam int V_DIV [NV] = '{1, 3, 4, 2, 0, 5, 7, 1, 2796};
    localparam int V_NE  [NV] = '{5, 9, 8, 7, 6, 12, 14, 4, 2796};
    localparam int V_EXP [NV] = '{5, 3, 2, 3, 0, 2, 2, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] stream_clk = '0;
    logic          ext_ref_a = 1'b0;
    logic          ext_ref_b = 1'b0;
    logic [SW-1:0] src_sel_a = '1;
    logic [SW-1:0] src_sel_b = '1;
    logic [DW-1:0] div_a = '0;
    logic [DW-1:0] div_b = '0;
    logic [TW-1:0] tmo_limit = TW'(40);
    logic          use_b = 1'b0;
    logic          ref_pulse_a, ref_pulse_b, ref_ok_a, ref_ok_b;
    logic          pll_ref, pll_ref_ok, pll_src_b;

    int checks = 0;
    int errors = 0;
    int n_a = 0, n_b = 0, n_p = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dual_ref_prescaler u_dual_ref_prescaler (
        .clk(clk), .rst_n(rst_n), .stream_clk(stream_clk),
        .ext_ref_a(ext_ref_a), .ext_ref_b(ext_ref_b),
        .src_sel_a(src_sel_a), .src_sel_b(src_sel_b),
        .div_a(div_a), .div_b(div_b), .tmo_limit(tmo_limit), .use_b(use_b),
        .ref_pulse_a(ref_pulse_a), .ref_pulse_b(ref_pulse_b),
        .ref_ok_a(ref_ok_a), .ref_ok_b(ref_ok_b),
        .pll_ref(pll_ref), .pll_ref_ok(pll_ref_ok), .pll_src_b(pll_src_b)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (ref_pulse_a) n_a <= n_a + 1;
            if (ref_pulse_b) n_b <= n_b + 1;
            if (pll_ref)     n_p <= n_p + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // all candidate sources rise together, 2 cycles high, 2 low
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            stream_clk = '1; ext_ref_a = 1'b1; ext_ref_b = 1'b1;
            idle(2);
            stream_clk = '0; ext_ref_a = 1'b0; ext_ref_b = 1'b0;
            idle(2);
        end
    endtask

    task automatic restart(input int sel, input int da, input int db);
        div_a = DW'(da); div_b = DW'(db);
        src_sel_a = '1; src_sel_b = '1;
        idle(3);
        src_sel_a = SW'(sel); src_sel_b = SW'(sel);
        idle(3);
    endtask

    function automatic string vtag(input int i);
        case (i)
            0: return "R3 pass-through";
            2: return "R1 external pin";
            4: return "R4 zero divider";
            7: return "R1 unused code";
            8: return "R5 large ratio";
            default: return "R2 divide";
        endcase
    endfunction

    initial begin
        int ba, bb, bp;
        idle(3);
        // R10 reset state
        chk("R10 reset pulse_a", int'(ref_pulse_a), 0);
        chk("R10 reset ok_a", int'(ref_ok_a), 0);
        chk("R10 reset pll_ref", int'(pll_ref), 0);
        chk("R10 reset pll_src_b", int'(pll_src_b), 0);
        rst_n = 1'b1;
        idle(3);

        for (int v = 0; v < NV; v++) begin
            restart(V_SEL[v], V_DIV[v], V_DIV[v]);
            ba = n_a; bb = n_b; bp = n_p;
            edges(V_NE[v]);
            idle(6);
            chk({vtag(v), " path A"}, n_a - ba, V_EXP[v]);
            chk({vtag(v), " path B"}, n_b - bb, V_EXP[v]);
            chk({vtag(v), " R9 pll follows A"}, n_p - bp, V_EXP[v]);
            if (V_DIV[v] == 0) chk("R4 ok low with zero divider", int'(ref_ok_a), 0);
        end

        // R7 health flag and timeout
        restart(0, 3, 3);
        edges(2);
        idle(3);
        chk("R7 ok after edge", int'(ref_ok_a), 1);
        chk("R9 pll_ref_ok follows A", int'(pll_ref_ok), 1);
        idle(60);
        chk("R7 ok after timeout", int'(ref_ok_a), 0);

        // R8 source change clears flag
        edges(1);
        idle(3);
        src_sel_a = SW'(5);
        idle(2);
        chk("R8 ok cleared on select change", int'(ref_ok_a), 0);
        chk("R8 path B untouched", int'(ref_ok_b), 1);
        edges(1);
        idle(4);
        chk("R8 ok after fresh edge", int'(ref_ok_a), 1);

        // R6 divider change deferred to pulse boundary
        restart(0, 4, 4);
        ba = n_a;
        edges(2);
        div_a = DW'(2);
        edges(6);
        idle(6);
        chk("R6 deferred divider", n_a - ba, 3);

        // R9 hand-over waits for the new path's pulse
        restart(0, 1, 4);
        bp = n_p;
        edges(2);
        idle(6);
        chk("R9 pll on A before switch", n_p - bp, 2);
        use_b = 1'b1;
        bp = n_p; bb = n_b;
        edges(8);
        idle(6);
        chk("R9 pll pulses across switch", n_p - bp, 3);
        chk("R9 path B pulses", n_b - bb, 2);
        chk("R9 pll_src_b after switch", int'(pll_src_b), 1);
        use_b = 1'b0;
        idle(4);
        chk("R9 switch back waits", int'(pll_src_b), 1);
        bp = n_p;
        edges(1);
        idle(6);
        chk("R9 switch back on A pulse", int'(pll_src_b), 0);
        chk("R9 switching pulse passed", n_p - bp, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule